// File: doc/BRIEF.md
# Sticky Floating-Point Status Register

This block holds a 32-bit floating-point/SIMD status and control word. Three write ports can update it. The first is a full-width port that loads any implemented bit and can clear flags. The second is an OR-only path for the cumulative saturation flag. The third is an OR-only path for the cumulative exception flags. Arithmetic units raise flags through the two OR-only paths. Those paths can only add flags and never remove one. Only the full-width port can clear a flag once it is set.

The read output is registered and always shows the whole 32-bit word, whichever port last touched it. After every accepted full-width write, a serialize signal stays high for one cycle. Surrounding pipeline logic uses it to hold later flag updates behind that write. When the full port and one or both flag paths write in the same cycle, the full value lands first and the flag contributions are ORed on top of it.

Top module: `fp_status_sticky`

## Requirements
- R1: A synchronous active-high reset drives `stat_q` to 0 and `serialize_o` to 0 in the cycle after it is sampled.
- R2: A full write (`full_we`=1) loads `full_wdata & IMPL_MASK` (default 0xFFCF_9F9F). Every bit outside IMPL_MASK reads 0, and any implemented bit may be cleared.
- R3: A saturation write (`sat_we`=1) ORs only bit 27 of `sat_wdata` (mask 0x0800_0000) into the word. All other bits keep their value.
- R4: An exception write (`exc_we`=1) ORs only bits 0-4 and bit 7 of `exc_wdata` (mask 0x0000_009F) into the word. All other bits keep their value.
- R5: Neither flag write can clear a bit. A bit that is set stays set until a full write or reset.
- R6: When a full write and a flag write share a cycle, the result is the masked full value ORed with the masked flag contributions.
- R7: When both flag writes share a cycle, both masked contributions are ORed in.
- R8: `serialize_o` is 1 in exactly the cycle after an accepted full write, and 0 otherwise.
- R9: `stat_q` is the whole register. It changes one clock after a write and holds when no port writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| full_we | input | 1 | Full-width write enable |
| full_wdata | input | 32 | Full-width write data |
| sat_we | input | 1 | Saturation flag OR-write enable |
| sat_wdata | input | 32 | Saturation write data (bit 27 used) |
| exc_we | input | 1 | Exception flag OR-write enable |
| exc_wdata | input | 32 | Exception write data (bits 0-4, 7 used) |
| stat_q | output | 32 | Registered status word |
| serialize_o | output | 1 | High one cycle after a full write |

## Verification
The bench walks a single set bit through all 32 positions on each flag path. A design with a wrong mask would show a stray bit, or miss bit 27 or an exception bit. Flag writes carrying zero data are issued over a fully set word to expose any path that clears a flag instead of ORing one in. All eight combinations of the three enables are swept with varied data. A design that lets the full write override a flag update in the same cycle, or drops one of two simultaneous flag writes, would lose those bits. Idle cycles and the serialize output are compared every cycle, so a missing or stretched serialize pulse is caught.

// File: rtl/fp_status_sticky.sv
module fp_status_sticky #(
  parameter int          W         = 32,
  parameter logic [W-1:0] IMPL_MASK = 32'hFFCF_9F9F,
  parameter logic [W-1:0] SAT_MASK  = 32'h0800_0000,
  parameter logic [W-1:0] EXC_MASK  = 32'h0000_009F
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         full_we,
  input  logic [W-1:0] full_wdata,
  input  logic         sat_we,
  input  logic [W-1:0] sat_wdata,
  input  logic         exc_we,
  input  logic [W-1:0] exc_wdata,
  output logic [W-1:0] stat_q,
  output logic         serialize_o
);

  localparam logic [W-1:0] SAT_EFF = SAT_MASK & IMPL_MASK;
  localparam logic [W-1:0] EXC_EFF = EXC_MASK & IMPL_MASK;

  logic [W-1:0] base, sat_or, exc_or, nxt;

  assign base   = full_we ? (full_wdata & IMPL_MASK) : stat_q;
  assign sat_or = sat_we ? (sat_wdata & SAT_EFF) : '0;
  assign exc_or = exc_we ? (exc_wdata & EXC_EFF) : '0;
  assign nxt    = base | sat_or | exc_or;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q      <= '0;
      serialize_o <= 1'b0;
    end else begin
      stat_q      <= nxt;
      serialize_o <= full_we;
    end
  end

endmodule

module fp_status_sticky_chk #(
  parameter int          W         = 32,
  parameter logic [W-1:0] IMPL_MASK = 32'hFFCF_9F9F,
  parameter logic [W-1:0] SAT_MASK  = 32'h0800_0000,
  parameter logic [W-1:0] EXC_MASK  = 32'h0000_009F
) (
  input logic         clk,
  input logic         rst,
  input logic         full_we,
  input logic [W-1:0] full_wdata,
  input logic         sat_we,
  input logic [W-1:0] sat_wdata,
  input logic         exc_we,
  input logic [W-1:0] exc_wdata,
  input logic [W-1:0] stat_q,
  input logic         serialize_o
);

  p_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (stat_q == '0 && !serialize_o));

  p_unimpl_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((stat_q & ~IMPL_MASK) == '0));

  p_full_load_r6: assert property (@(posedge clk) disable iff (rst)
    (full_we && !sat_we && !exc_we) |=> stat_q == ($past(full_wdata) & IMPL_MASK));

  p_sat_or_r3: assert property (@(posedge clk) disable iff (rst)
    (sat_we && !full_we && !exc_we) |=>
      stat_q == ($past(stat_q) | ($past(sat_wdata) & SAT_MASK)));

  p_exc_or_r4: assert property (@(posedge clk) disable iff (rst)
    (exc_we && !full_we && !sat_we) |=>
      stat_q == ($past(stat_q) | ($past(exc_wdata) & EXC_MASK)));

  p_no_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(full_we)) |-> (($past(stat_q) & ~stat_q) == '0));

  p_serialize_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (serialize_o == $past(full_we)));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!full_we && !sat_we && !exc_we) |=> $stable(stat_q));

endmodule

bind fp_status_sticky fp_status_sticky_chk #(
  .W(W), .IMPL_MASK(IMPL_MASK), .SAT_MASK(SAT_MASK), .EXC_MASK(EXC_MASK)
) chk_i (
  .clk(clk), .rst(rst),
  .full_we(full_we), .full_wdata(full_wdata),
  .sat_we(sat_we), .sat_wdata(sat_wdata),
  .exc_we(exc_we), .exc_wdata(exc_wdata),
  .stat_q(stat_q), .serialize_o(serialize_o)
);

// File: tb/fp_status_sticky_tb.sv
module fp_status_sticky_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] IMPL = 32'hFFCF_9F9F;
  localparam logic [31:0] SATM = 32'h0800_0000;
  localparam logic [31:0] EXCM = 32'h0000_009F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic full_we = 1'b0, sat_we = 1'b0, exc_we = 1'b0;
  logic [31:0] full_wdata = '0, sat_wdata = '0, exc_wdata = '0;
  logic [31:0] stat_q;
  logic serialize_o;

  int checks = 0;
  int failures = 0;
  logic [31:0] model = '0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_status_sticky dut_i (
    .clk(clk), .rst(rst),
    .full_we(full_we), .full_wdata(full_wdata),
    .sat_we(sat_we), .sat_wdata(sat_wdata),
    .exc_we(exc_we), .exc_wdata(exc_wdata),
    .stat_q(stat_q), .serialize_o(serialize_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag,
                      input logic fw, input logic [31:0] fd,
                      input logic sw, input logic [31:0] sd,
                      input logic ew, input logic [31:0] ed);
    logic [31:0] e;
    @(negedge clk);
    full_we = fw; full_wdata = fd;
    sat_we = sw; sat_wdata = sd;
    exc_we = ew; exc_wdata = ed;
    e = fw ? (fd & IMPL) : model;
    if (sw) e = e | (sd & SATM);
    if (ew) e = e | (ed & EXCM);
    model = e;
    @(posedge clk);
    #(CLK_PERIOD/4);
    full_we = 1'b0; sat_we = 1'b0; exc_we = 1'b0;
    check(tag, stat_q, model);
    check("R8", {31'd0, serialize_o}, {31'd0, fw});
  endtask

  function automatic logic [31:0] nxt_lfsr(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check("R1", stat_q, 32'h0);
    check("R1", {31'd0, serialize_o}, 32'h0);
    @(negedge clk);
    rst = 1'b0;

    // R2: full writes, masking and clearing
    step("R2", 1, 32'hFFFF_FFFF, 0, 0, 0, 0);
    step("R2", 1, 32'hA5A5_A5A5, 0, 0, 0, 0);
    step("R2", 1, 32'h0000_0000, 0, 0, 0, 0);
    for (int i = 0; i < 32; i++) step("R2", 1, 32'h1 << i, 0, 0, 0, 0);

    // R3: walking bit through the saturation path
    for (int i = 0; i < 32; i++) begin
      step("R2", 1, 32'h0, 0, 0, 0, 0);
      step("R3", 0, 0, 1, 32'h1 << i, 0, 0);
    end
    step("R3", 1, 32'h0, 0, 0, 0, 0);
    step("R3", 0, 0, 1, 32'hFFFF_FFFF, 0, 0);

    // R4: walking bit through the exception path
    for (int i = 0; i < 32; i++) begin
      step("R2", 1, 32'h0, 0, 0, 0, 0);
      step("R4", 0, 0, 0, 0, 1, 32'h1 << i);
    end
    step("R4", 1, 32'h0, 0, 0, 0, 0);
    step("R4", 0, 0, 0, 0, 1, 32'hFFFF_FFFF);

    // R5: zero-data flag writes over a full word
    step("R5", 1, 32'hFFFF_FFFF, 0, 0, 0, 0);
    step("R5", 0, 0, 1, 32'h0, 0, 0);
    step("R5", 0, 0, 0, 0, 1, 32'h0);
    step("R5", 0, 0, 1, 32'h0, 1, 32'h0);
    step("R5", 0, 0, 1, 32'hF7FF_FFFF, 1, 32'hFFFF_FF60);

    // R9: hold with no write
    for (int i = 0; i < 4; i++) step("R9", 0, 0, 0, 0, 0, 0);

    // R6/R7: same-cycle combinations
    step("R6", 1, 32'h0, 1, 32'hFFFF_FFFF, 0, 0);
    step("R6", 1, 32'h0, 0, 0, 1, 32'hFFFF_FFFF);
    step("R6", 1, 32'h1234_5600, 1, 32'h0800_0000, 1, 32'h0000_0081);
    step("R2", 1, 32'h0, 0, 0, 0, 0);
    step("R7", 0, 0, 1, 32'h0800_0000, 1, 32'h0000_0011);

    // Sweep over all enable combinations with varied data
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a, b, c;
      lfsr = nxt_lfsr(lfsr); a = lfsr;
      lfsr = nxt_lfsr(lfsr); b = lfsr;
      lfsr = nxt_lfsr(lfsr); c = lfsr;
      case (n % 8)
        0: step("R9", 0, a, 0, b, 0, c);
        1: step("R3", 0, a, 1, b, 0, c);
        2: step("R4", 0, a, 0, b, 1, c);
        3: step("R7", 0, a, 1, b, 1, c);
        4: step("R2", 1, a, 0, b, 0, c);
        5: step("R6", 1, a, 1, b, 0, c);
        6: step("R6", 1, a, 0, b, 1, c);
        default: step("R6", 1, a, 1, b, 1, c);
      endcase
    end

    // R1: reset after activity
    @(negedge clk);
    full_we = 1'b1; full_wdata = 32'hFFFF_FFFF;
    rst = 1'b1;
    @(posedge clk);
    #(CLK_PERIOD/4);
    full_we = 1'b0;
    check("R1", stat_q, 32'h0);
    check("R1", {31'd0, serialize_o}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    model = '0;
    step("R9", 0, 0, 0, 0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule